// File: doc/BRIEF.md
# Threshold Hamming Weight Comparator

This block is purely combinational. It raises a single flag when the number of set bits in an N-bit input vector is at least a threshold. The threshold arrives on a port, so it can be programmed once at startup and left alone. A synthesis parameter can instead hard-wire it, and the port is then ignored.

The block never forms the full population count and then compares it with the threshold. N-1 of the input bits are summed by a tree of ripple-carry adders that get one bit wider at each level. That Q-bit partial count then meets the value 2^Q minus the threshold in a final carry-only row. The remaining input bit is the carry-in of that row. The flag is the carry out of the row, which means the total has reached 2^Q. A zero threshold gives a preload of exactly 2^Q, which does not fit in Q bits, so a separate strobe forces the flag for that case.

Top module: `hwcThresholdCmp`

## Requirements
- R1: `atLeast` is 1 exactly when the number of ones in `hwVec` is greater than or equal to the unsigned value on `threshold`, for every threshold from 0 to N.
- R2: With a threshold of 0, `atLeast` is 1 for every input vector, including all zeros.
- R3: The most significant input bit `hwVec[N-1]` counts exactly like any other bit. With only that bit set and a threshold of 1, `atLeast` is 1. With that bit and bit 0 set and a threshold of 2, `atLeast` is 1.
- R4: At the top of the range (default N=15), all fifteen bits set with a threshold of 15 gives 1. Fourteen bits set with a threshold of 15 gives 0, whether the missing bit is bit 0 or bit 14.
- R5: The output depends only on the current inputs. A change on `hwVec` or `threshold` shows on `atLeast` with no clock edge in between.
- R6: When the parameter FIXED_K is 0 or more, the `threshold` port has no effect. `atLeast` is 1 exactly when the number of ones in `hwVec` is at least FIXED_K.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hwVec | input | N | Vector whose set bits are counted |
| threshold | input | Q = clog2(N+1) | Unsigned threshold; ignored when FIXED_K >= 0 |
| atLeast | output | 1 | 1 when the count of ones is at least the threshold |

## Verification
The bench targets the zero threshold, since its preload overflows Q bits. A design that drops the forcing strobe would report 0 for an empty vector there. It also drives vectors whose only set bit is the one routed in as carry-in. A tree that counted that bit twice, or left it out, would be off by one at every threshold. The all-ones and fourteen-ones vectors against the largest threshold probe the exact-overflow point, where a chain carrying out one place too early or too late flips the flag. A second instance with a hard-wired threshold receives changing values on its threshold port; any leakage of that port into the pruned AND/OR carry chain shows up as a wrong flag.

// File: rtl/hwcPkg.sv
package hwcPkg;

  // Control strobes handed from the threshold logic to the datapath.
  typedef struct packed {
    logic alwaysHit;   // threshold of zero: preload would be 2^Q, flag forced
  } hwcStrobe_t;

  // Number of adder nodes at tree level lvl (1 = leaves of full adders).
  function automatic int levelNodes(input int q, input int lvl);
    return 2 ** (q - 1 - lvl);
  endfunction

  // Bit offset of level lvl results inside the flattened tree vector.
  function automatic int levelBase(input int q, input int lvl);
    int b;
    b = 0;
    for (int m = 1; m < lvl; m++) b += levelNodes(q, m) * (m + 1);
    return b;
  endfunction

  // First padded input bit used as carry-in by the nodes of level lvl >= 2.
  function automatic int extraBase(input int q, input int lvl);
    int b;
    b = 3 * levelNodes(q, 1);
    for (int m = 2; m < lvl; m++) b += levelNodes(q, m);
    return b;
  endfunction

endpackage

// File: rtl/hwcRipple.sv
module hwcRipple #(
  parameter int W = 1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W:0]   sum
);
  logic [W:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : gBit
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
  end

  assign sum[W] = carry[W];
endmodule

// File: rtl/hwcPopTree.sv
module hwcPopTree
  import hwcPkg::*;
#(
  parameter int N = 15,
  parameter int Q = $clog2(N + 1)
) (
  input  logic [N-2:0] bitsIn,
  output logic [Q-1:0] total
);
  localparam int M     = 2 ** Q - 1;            // bits one full tree absorbs
  localparam int TBITS = levelBase(Q, Q);       // all level results, flattened

  logic [M-1:0]     padded;
  logic [TBITS-1:0] treeBits;

  assign padded = M'(bitsIn);

  for (genvar lvl = 1; lvl < Q; lvl++) begin : gLvl
    localparam int NODES = levelNodes(Q, lvl);
    localparam int OUTB  = levelBase(Q, lvl);
    localparam int INB   = levelBase(Q, lvl - 1);
    localparam int EXB   = extraBase(Q, lvl);
    for (genvar j = 0; j < NODES; j++) begin : gNode
      if (lvl == 1) begin : gLeaf
        hwcRipple #(.W(1)) uAdd (
          .a  (padded[3*j]),
          .b  (padded[3*j+1]),
          .cin(padded[3*j+2]),
          .sum(treeBits[OUTB + 2*j +: 2])
        );
      end else begin : gInner
        hwcRipple #(.W(lvl)) uAdd (
          .a  (treeBits[INB + (2*j)*lvl +: lvl]),
          .b  (treeBits[INB + (2*j+1)*lvl +: lvl]),
          .cin(padded[EXB + j]),
          .sum(treeBits[OUTB + j*(lvl+1) +: lvl+1])
        );
      end
    end
  end

  assign total = treeBits[levelBase(Q, Q - 1) +: Q];

  // R1: the adder tree yields the true population count of its bits
  always_comb begin
    tree_sum_chk: assert (int'(total) == $countones(bitsIn))
      else $error("tree sum %0d differs from count of ones", total);
  end
endmodule

// File: rtl/hwcThresholdCtl.sv
module hwcThresholdCtl
  import hwcPkg::*;
#(
  parameter int Q       = 4,
  parameter int FIXED_K = -1
) (
  input  logic [Q-1:0] threshold,
  output logic [Q-1:0] preload,
  output hwcStrobe_t   strobe
);
  logic [Q-1:0] effK;

  if (FIXED_K >= 0) begin : gFixed
    assign effK = Q'(FIXED_K);
  end else begin : gRuntime
    assign effK = threshold;
  end

  assign preload          = Q'(0) - effK;
  assign strobe.alwaysHit = (effK == '0);

  // R1: preload plus threshold lands exactly on 2^Q (or both are zero)
  always_comb begin
    preload_chk: assert (strobe.alwaysHit ? (preload == '0)
                         : (({1'b0, preload} + {1'b0, effK}) == (Q+1)'(2 ** Q)))
      else $error("preload %0d does not complement threshold %0d", preload, effK);
  end
endmodule

// File: rtl/hwcCarryChain.sv
module hwcCarryChain
  import hwcPkg::*;
#(
  parameter int Q       = 4,
  parameter int FIXED_K = -1
) (
  input  logic [Q-1:0] partial,
  input  logic [Q-1:0] preload,
  input  logic         seed,
  input  hwcStrobe_t   strobe,
  output logic         hit
);
  localparam logic [Q-1:0] FIXED_PRE = Q'(0) - Q'(FIXED_K < 0 ? 0 : FIXED_K);

  logic [Q:0] carry;

  assign carry[0] = seed;

  for (genvar i = 0; i < Q; i++) begin : gStage
    if (FIXED_K >= 0) begin : gPruned
      if (FIXED_PRE[i]) begin : gOr
        assign carry[i+1] = carry[i] | partial[i];
      end else begin : gAnd
        assign carry[i+1] = carry[i] & partial[i];
      end
    end else begin : gFull
      assign carry[i+1] = (preload[i] & partial[i]) |
                          (carry[i] & (preload[i] | partial[i]));
    end
  end

  assign hit = carry[Q] | strobe.alwaysHit;

  // R1: the carry-only row agrees with a wide addition of its operands
  always_comb begin
    chain_carry_chk: assert (hit == (strobe.alwaysHit |
        ((({1'b0, preload} + {1'b0, partial} + (Q+1)'(seed)) >> Q) != '0)))
      else $error("carry chain result %0b disagrees with wide sum", hit);
  end
endmodule

// File: rtl/hwcThresholdCmp.sv
module hwcThresholdCmp
  import hwcPkg::*;
#(
  parameter  int N       = 15,
  parameter  int FIXED_K = -1,
  localparam int Q       = $clog2(N + 1)
) (
  input  logic [N-1:0] hwVec,
  input  logic [Q-1:0] threshold,
  output logic         atLeast
);
  logic [Q-1:0] partial;
  logic [Q-1:0] preload;
  hwcStrobe_t   strobe;

  hwcThresholdCtl #(.Q(Q), .FIXED_K(FIXED_K)) uCtl (
    .threshold(threshold),
    .preload  (preload),
    .strobe   (strobe)
  );

  hwcPopTree #(.N(N), .Q(Q)) uTree (
    .bitsIn(hwVec[N-2:0]),
    .total (partial)
  );

  hwcCarryChain #(.Q(Q), .FIXED_K(FIXED_K)) uChain (
    .partial(partial),
    .preload(preload),
    .seed   (hwVec[N-1]),
    .strobe (strobe),
    .hit    (atLeast)
  );

  // R1: flag equals the comparison of population count against threshold
  always_comb begin
    result_chk: assert (atLeast == ($countones(hwVec) >=
                        ((FIXED_K >= 0) ? FIXED_K : int'(threshold))))
      else $error("flag %0b wrong for vector %h", atLeast, hwVec);
  end

  // R2: a zero threshold always yields a set flag
  always_comb begin
    if (FIXED_K < 0 && threshold == '0) begin
      always_hit_chk: assert (atLeast)
        else $error("zero threshold did not force the flag");
    end
  end
endmodule

// File: tb/test_hwcThresholdCmp.sv
module test_hwcThresholdCmp;
  localparam int N  = 15;
  localparam int Q  = 4;
  localparam int FK = 5;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] hwVec = '0;
  logic [Q-1:0] threshold = '0;
  logic atLeast, atFixed;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;   // 50 MHz

  hwcThresholdCmp #(.N(N)) i_hwcThresholdCmp (
    .hwVec(hwVec), .threshold(threshold), .atLeast(atLeast)
  );

  hwcThresholdCmp #(.N(N), .FIXED_K(FK)) i_fixedCmp (
    .hwVec(hwVec), .threshold(threshold), .atLeast(atFixed)
  );

  // {vector, threshold, expected}
  localparam logic [19:0] TABLE [16] = '{
    {15'h0000, 4'd0,  1'b1},   // R2
    {15'h0000, 4'd1,  1'b0},   // R1
    {15'h7FFF, 4'd15, 1'b1},   // R4
    {15'h7FFE, 4'd15, 1'b0},   // R4
    {15'h3FFF, 4'd15, 1'b0},   // R4
    {15'h3FFF, 4'd14, 1'b1},   // R1
    {15'h4000, 4'd1,  1'b1},   // R3
    {15'h4001, 4'd2,  1'b1},   // R3
    {15'h0001, 4'd2,  1'b0},   // R1
    {15'h00FF, 4'd8,  1'b1},   // R1
    {15'h00FF, 4'd9,  1'b0},   // R1
    {15'h5555, 4'd8,  1'b1},   // R1
    {15'h5555, 4'd9,  1'b0},   // R1
    {15'h2AAA, 4'd7,  1'b1},   // R1
    {15'h2AAA, 4'd8,  1'b0},   // R1
    {15'h7FFF, 4'd0,  1'b1}    // R2
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s vec=%h thr=%0d actual=%0b expected=%0b",
               req, hwVec, threshold, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] v, input logic [Q-1:0] k);
    @(posedge clk);
    #2;
    hwVec = v;
    threshold = k;
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] spread(input int ones, input int rot);
    logic [2*N-1:0] w;
    w = (2*N)'((32'd1 << ones) - 1);
    w = (w << rot) | (w >> (N - rot));
    return w[N-1:0];
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 reset state", atLeast, 1'b1);

    foreach (TABLE[i]) begin
      apply(TABLE[i][19:5], TABLE[i][4:1]);
      check("R1/R2/R3/R4 table", atLeast, TABLE[i][0]);
      check("R6 table fixed", atFixed, ($countones(hwVec) >= FK));
    end

    // R5: output follows inputs without a clock edge
    @(posedge clk);
    #3;
    hwVec = 15'h7FFF; threshold = 4'd15;
    #1;
    check("R5 combinational rise", atLeast, 1'b1);
    hwVec = 15'h7FFD;
    #1;
    check("R5 combinational fall", atLeast, 1'b0);
    threshold = 4'd14;
    #1;
    check("R5 threshold change", atLeast, 1'b1);

    // R1 sweep: every threshold, vectors around every count
    for (int k = 0; k <= N; k++) begin
      for (int c = 0; c <= N; c++) begin
        apply(spread(c, int'($urandom_range(0, N - 1))), Q'(k));
        check("R1 count sweep", atLeast, (c >= k));
        check("R6 fixed ignores port", atFixed, (c >= FK));
      end
      for (int r = 0; r < 150; r++) begin
        apply(N'($urandom), Q'(k));
        check(k == 0 ? "R2 random" : "R1 random", atLeast,
              ($countones(hwVec) >= k));
        check("R6 random", atFixed, ($countones(hwVec) >= FK));
      end
    end

    // R6: hold the vector, sweep the port on the fixed instance
    for (int k = 0; k <= N; k++) begin
      apply(15'h0013, Q'(k));     // three ones, below FK
      check("R6 port sweep low", atFixed, 1'b0);
      apply(15'h001F, Q'(k));     // five ones, at FK
      check("R6 port sweep at", atFixed, 1'b1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule